// File: doc/BRIEF.md
# ETU Generator and Wait-Time Counter

This block sets the bit timing of a smart-card UART. A two-stage divider produces one elementary time unit (ETU) tick every F/D card-clock cycles. The first stage divides by 31 or 32 and the second stage by a programmable multiplier, so every ratio that is a whole multiple of 31 or 32 can be reached. Firmware picks the stage settings that give the wanted baud rate from its reference clock. The divider advances only on cycles where the card clock enable is high. A character-start event restarts it, so the ETU phase lines up with the incoming start bit. A mid-bit strobe then marks the sampling point half an ETU into each bit.

A 28-bit wait counter guards against a silent card. Each character-start or character-end event loads it with the normal wait value, and each ETU tick counts it down. When it runs out it sets a sticky timeout flag, which stays set until the host clears it. A waiting-time-extension load puts a longer value into the running count for the current wait only. The next reload uses the normal value again.

Top module: `etu_wait_timer`

## Requirements
- R1: During and right after reset, `etu_tick`, `sample_stb` and `timeout` are low.
- R2: The ETU length N in enabled cycles is P*M. P is 31 when `pre_sel`=0 and 32 when `pre_sel`=1. M is `mult`, and a `mult` of 0 acts as 1. `etu_tick` is a one-cycle pulse that repeats every N enabled cycles.
- R3: `start_evt` restarts the divider. With `clk_en` held high and `start_evt` sampled at clock edge s, `etu_tick` is high in the cycle after edge s+j*N, for j=1,2,...
- R4: After a restart at edge s, `sample_stb` is high in the cycle after edge s+j*N+floor(N/2), for j=0,1,..., and never in the same cycle as `etu_tick`.
- R5: While `clk_en` is low, the divider holds its state. A stretch of G disabled cycles delays every later tick and strobe by G cycles, and no tick or strobe follows a disabled cycle.
- R6: `start_evt` or `char_end` loads the wait count with `wait_reload` (0 acts as 1). `timeout` rises in the same cycle as the `wait_reload`-th `etu_tick` after the load.
- R7: `timeout` is sticky and is cleared by `to_clr`. When a timeout occurs in the same cycle as `to_clr`, `timeout` is set.
- R8: A `wtx_load` pulse replaces the running wait count with `wtx_val` for the current wait. The next `start_evt` or `char_end` reload uses `wait_reload` again.
- R9: After a timeout the wait counter stops. Once `timeout` is cleared, it stays low until the counter has been reloaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Card clock enable; the divider advances only when high |
| pre_sel | input | 1 | Prescaler select: 0 divides by 31, 1 divides by 32 |
| mult | input | MULT_W | ETU multiplier M (0 acts as 1) |
| start_evt | input | 1 | Character start edge: restarts the ETU and reloads the wait counter |
| char_end | input | 1 | Character end: reloads the wait counter |
| wait_reload | input | WAIT_W | Normal wait length in ETUs |
| wtx_load | input | 1 | Loads the extension value into the running wait count |
| wtx_val | input | WAIT_W | Extended wait length in ETUs |
| to_clr | input | 1 | Clears the sticky timeout flag |
| etu_tick | output | 1 | One-cycle pulse at the end of each ETU |
| sample_stb | output | 1 | One-cycle pulse at the middle of each ETU |
| timeout | output | 1 | Sticky wait-time expiry flag |

## Verification
The divider is run with both prescaler choices and with odd, even, zero and large multipliers. Odd multipliers with P=31 separate a correct mid-bit rounding from an off-by-one strobe. Restarts in the middle of a running ETU show whether the phase really resets rather than continuing. A gap in the clock enable tells a frozen divider from one that keeps counting. The wait counter is tried with zero and small reloads, with an extension load placed mid-wait followed by a character-end reload, and with a clear that collides with expiry. Together these show whether the extension reaches past one wait and whether set or clear takes priority.

// File: rtl/etu_wait_timer.sv
module etu_wait_timer #(
  parameter int MULT_W = 8,
  parameter int WAIT_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              pre_sel,
  input  logic [MULT_W-1:0] mult,
  input  logic              start_evt,
  input  logic              char_end,
  input  logic [WAIT_W-1:0] wait_reload,
  input  logic              wtx_load,
  input  logic [WAIT_W-1:0] wtx_val,
  input  logic              to_clr,
  output logic              etu_tick,
  output logic              sample_stb,
  output logic              timeout
);
  localparam int PRE_W = 5;

  logic [PRE_W-1:0]  pre_cnt;
  logic [MULT_W-1:0] mul_cnt;
  logic [WAIT_W-1:0] wcnt;
  logic              armed;

  wire [PRE_W-1:0]  pre_last = pre_sel ? PRE_W'(31) : PRE_W'(30);
  wire [PRE_W-1:0]  pre_half = pre_sel ? PRE_W'(15) : PRE_W'(14);
  wire [MULT_W-1:0] m_eff    = (mult == '0) ? MULT_W'(1) : mult;
  wire [MULT_W-1:0] mul_last = m_eff - MULT_W'(1);
  wire [MULT_W-1:0] mul_half = m_eff[0] ? (m_eff >> 1) : ((m_eff >> 1) - MULT_W'(1));
  wire              pre_end  = (pre_cnt == pre_last);

  wire etu_end = clk_en & pre_end & (mul_cnt == mul_last);
  wire mid_pt  = clk_en & (mul_cnt == mul_half) & (m_eff[0] ? (pre_cnt == pre_half) : pre_end);
  wire tick_ev = etu_end & ~start_evt;
  wire mid_ev  = mid_pt & ~start_evt;

  wire reload  = start_evt | char_end;
  wire expire  = armed & tick_ev & (wcnt <= WAIT_W'(1)) & ~wtx_load & ~reload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      mul_cnt <= '0;
    end else if (start_evt) begin
      pre_cnt <= '0;
      mul_cnt <= '0;
    end else if (clk_en) begin
      if (pre_end) begin
        pre_cnt <= '0;
        mul_cnt <= (mul_cnt >= mul_last) ? '0 : mul_cnt + MULT_W'(1);
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      etu_tick   <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      etu_tick   <= tick_ev;
      sample_stb <= mid_ev;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= '0;
      armed <= 1'b0;
    end else if (wtx_load) begin
      wcnt  <= wtx_val;
      armed <= 1'b1;
    end else if (reload) begin
      wcnt  <= wait_reload;
      armed <= 1'b1;
    end else if (armed && tick_ev) begin
      if (wcnt <= WAIT_W'(1)) begin
        wcnt  <= '0;
        armed <= 1'b0;
      end else begin
        wcnt <= wcnt - WAIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      timeout <= 1'b0;
    else if (expire) timeout <= 1'b1;
    else if (to_clr) timeout <= 1'b0;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) etu_tick |=> !etu_tick); // R2
  AST_NO_TICK_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start_evt |=> !etu_tick && !sample_stb); // R3
  AST_STB_APART_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n) !(sample_stb && etu_tick)); // R4
  AST_FREEZE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n) !clk_en |=> !etu_tick && !sample_stb); // R5
  AST_TIMEOUT_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout) |-> etu_tick); // R6
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) timeout && !to_clr |=> timeout); // R7
  AST_CLEAR_ONLY_BY_HOST: assert property (@(posedge clk) disable iff (!rst_n) $fell(timeout) |-> $past(to_clr)); // R7
endmodule

// File: tb/etu_wait_timer_tb.sv
module etu_wait_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        pre_sel = 1'b0;
  logic [7:0]  mult = 8'd1;
  logic        start_evt = 1'b0;
  logic        char_end = 1'b0;
  logic [27:0] wait_reload = 28'd1;
  logic        wtx_load = 1'b0;
  logic [27:0] wtx_val = 28'd0;
  logic        to_clr = 1'b0;
  logic        etu_tick, sample_stb, timeout;

  etu_wait_timer u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pre_sel(pre_sel), .mult(mult),
    .start_evt(start_evt), .char_end(char_end), .wait_reload(wait_reload),
    .wtx_load(wtx_load), .wtx_val(wtx_val), .to_clr(to_clr),
    .etu_tick(etu_tick), .sample_stb(sample_stb), .timeout(timeout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  int q_tick[$];
  int q_stb[$];
  int q_to[$];
  int win_lo = 1;
  int win_hi = 0;
  string cur_tag = "R1";
  logic to_prev = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cyc >= win_lo && cyc <= win_hi) begin
      if (etu_tick)
        chk({cur_tag, " tick"}, cyc, (q_tick.size() == 0) ? -1 : q_tick.pop_front());
      if (sample_stb)
        chk({cur_tag, " strobe"}, cyc, (q_stb.size() == 0) ? -1 : q_stb.pop_front());
      if (timeout && !to_prev)
        chk({cur_tag, " timeout"}, cyc, (q_to.size() == 0) ? -1 : q_to.pop_front());
    end
    to_prev = timeout;
  end

  task automatic goto(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push_periodic(input int s, input int n, input int nt);
    for (int j = 1; j <= nt; j++) q_tick.push_back(s + j*n);
    for (int j = 0; j < nt; j++) q_stb.push_back(s + j*n + n/2);
  endtask

  task automatic begin_run(input bit psel, input int m, input int rld, input string tag,
                           output int s, output int n);
    @(negedge clk);
    pre_sel = psel; mult = 8'(m); wait_reload = 28'(rld);
    start_evt = 1'b1; to_clr = 1'b1;
    s = cyc + 1;
    n = (psel ? 32 : 31) * ((m == 0) ? 1 : m);
    cur_tag = tag;
    win_lo = s;
    @(negedge clk);
    start_evt = 1'b0; to_clr = 1'b0;
  endtask

  task automatic drain(input int hi);
    win_hi = hi;
    goto(hi + 1);
    chk({cur_tag, " missed events"}, q_tick.size() + q_stb.size() + q_to.size(), 0);
    q_tick.delete(); q_stb.delete(); q_to.delete();
  endtask

  task automatic run(input bit psel, input int m, input int rld, input int nt, input string tag);
    int s, n, r;
    q_tick.delete(); q_stb.delete(); q_to.delete();
    win_hi = 0;
    begin_run(psel, m, rld, tag, s, n);
    push_periodic(s, n, nt);
    r = (rld == 0) ? 1 : rld;
    if (r <= nt) q_to.push_back(s + r*n);
    drain(s + nt*n + 1);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R1..all actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s, n;
    repeat (3) @(negedge clk);
    chk("R1 etu_tick in reset", int'(etu_tick), 0);
    chk("R1 sample_stb in reset", int'(sample_stb), 0);
    chk("R1 timeout in reset", int'(timeout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 timeout after reset", int'(timeout), 0);
    chk("R1 tick after reset", int'(etu_tick), 0);

    run(1'b0, 1, 100, 4, "R2 R3 R4 P31 M1");
    run(1'b1, 3, 2, 4, "R2 R4 R6 P32 M3");
    run(1'b0, 3, 4, 5, "R2 R4 R6 P31 M3");
    run(1'b0, 4, 1, 3, "R2 R4 R6 P31 M4");
    run(1'b1, 0, 0, 3, "R2 R6 mult zero");
    run(1'b0, 12, 2, 3, "R2 R3 R6 P31 M12");

    // R5: clock-enable gap of 10 cycles before the first strobe
    q_tick.delete(); q_stb.delete(); q_to.delete(); win_hi = 0;
    begin_run(1'b1, 2, 2, "R5 freeze", s, n);
    q_stb.push_back(s + 32 + 10);
    q_tick.push_back(s + 64 + 10);
    q_stb.push_back(s + 64 + 32 + 10);
    q_tick.push_back(s + 128 + 10);
    q_to.push_back(s + 128 + 10);
    win_hi = s + 140;
    goto(s + 5);  clk_en = 1'b0;
    goto(s + 15); clk_en = 1'b1;
    drain(s + 139);

    // R8: extension mid-wait, then a char_end reload returns to the normal value
    win_hi = 0;
    begin_run(1'b0, 1, 3, "R8 wtx", s, n);
    push_periodic(s, n, 9);
    q_to.push_back(s + 6*n);
    q_to.push_back(s + 9*n);
    win_hi = s + 9*n + 1;
    goto(s + n + 2);   wtx_load = 1'b1; wtx_val = 28'd5;
    @(negedge clk);    wtx_load = 1'b0;
    goto(s + 6*n + 2); to_clr = 1'b1;
    @(negedge clk);    to_clr = 1'b0;
    chk("R7 cleared by to_clr", int'(timeout), 0);
    goto(s + 6*n + 5); char_end = 1'b1; cur_tag = "R6 R8 char_end reload";
    @(negedge clk);    char_end = 1'b0;
    drain(s + 9*n + 1);

    // R7 set wins over clear; R9 no new timeout without a reload
    win_hi = 0;
    begin_run(1'b1, 1, 2, "R7 R9", s, n);
    push_periodic(s, n, 6);
    q_to.push_back(s + 2*n);
    win_hi = s + 6*n + 1;
    goto(s + 2*n - 1); to_clr = 1'b1;
    @(negedge clk);    to_clr = 1'b0;
    goto(s + 2*n + 3);
    chk("R7 set wins over clear", int'(timeout), 1);
    goto(s + 2*n + 5); to_clr = 1'b1;
    @(negedge clk);    to_clr = 1'b0;
    chk("R7 host clear", int'(timeout), 0);
    drain(s + 6*n + 1);
    chk("R9 no timeout without reload", int'(timeout), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule